// File: doc/BRIEF.md
# Stretched Status LED Multiplexer

This block drives a bank of status LEDs for a multiport repeater, with one LED bit per port. Each port reports five live conditions: carrier activity, collision, link good, partitioned and received polarity. A set of attribute-select inputs picks which of these conditions the LED bus shows. A bank-select input swaps the upper LED bits over to the status of an expansion bus or of two auxiliary ports.

Carrier and collision events can be very short. To keep them visible to a person, each one is held by its own timer. The timer counts a slow clock-enable tick, which is made inside the block by dividing the system clock. The hold restarts on every new event, so the hold time is measured from the last event. Link, partition and polarity pass through without a hold. The LED bus is registered once, so the LEDs never glitch.

Top module: `led_status_mux`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `led_o` is all zeros, and every carrier and collision hold is cleared.
- R2: When port i's carrier input is high on a clock edge, its held carrier indication is set from the next cycle. After the input drops, the indication stays set for at least HOLD_TICKS tick periods (TICK_DIV cycles each). It clears no later than HOLD_TICKS+2 tick periods after the drop.
- R3: Port i's collision input is held in the same way as in R2, with its own timer.
- R4: An event that arrives while a hold is running reloads the timer. The indication never drops in between, and the new hold is measured from the last event.
- R5: With bank select low, the link, partition and polarity attributes show the live inputs with no hold. LED bit i shows port i.
- R6: The select priority from highest to lowest is carrier, collision, link, partition, polarity. When no select is asserted, `led_o` is all zeros.
- R7: With bank select high and carrier as the winning select, bit EXP_POS (default 6) shows the held expansion-bus carrier. All other bits show the held port carriers.
- R8: With bank select high and collision as the winning select, bit EXP_POS shows the held expansion-bus collision. All other bits show the held port collisions.
- R9: With bank select high and link as the winning select, bits AUX_POS+1 and AUX_POS (default 7:6) show `aux_link_i[1:0]` unchanged, with index 1 on the upper bit. A 1 means link up, or no loopback error on a non-transceiver attachment. All other bits show the port link inputs.
- R10: With bank select high and partition as the winning select, bits AUX_POS+1 and AUX_POS show `aux_pol_i[1:0]`, the received polarity of the auxiliary ports. All other bits show the port partition inputs.
- R11: With polarity as the winning select, every bit shows the port polarity input, whatever the state of bank select.
- R12: `led_o` changes exactly one clock edge after its inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_crs | input | 1 | Show carrier activity |
| sel_col | input | 1 | Show collision |
| sel_link | input | 1 | Show link status |
| sel_part | input | 1 | Show partition status |
| sel_pol | input | 1 | Show received polarity |
| bank_sel | input | 1 | Remap the upper bits to expansion or auxiliary status |
| crs_i | input | LED_W (8) | Live carrier per port |
| col_i | input | LED_W (8) | Live collision per port |
| link_i | input | LED_W (8) | Link good per port |
| part_i | input | LED_W (8) | Partitioned per port |
| pol_i | input | LED_W (8) | Received polarity per port |
| exp_crs_i | input | 1 | Live expansion-bus carrier |
| exp_col_i | input | 1 | Live expansion-bus collision |
| aux_link_i | input | 2 | Auxiliary port link, or no-loopback-error flag |
| aux_pol_i | input | 2 | Auxiliary port received polarity |
| led_o | output | LED_W (8) | Registered LED drive, 1 = lit |

## Verification
Two things can fall in the same cycle: a fresh carrier event can arrive just as the decrementing tick would run a hold out. The bench provokes this by dropping carrier on a port, letting the hold run through the whole guaranteed window, and then raising carrier again at the edge of expiry. It samples the LED every cycle across both holds and passes only if the bit never goes dark before the final expiry window. It also checks that the bit is dark once that window has closed.

// File: rtl/led_status_pkg.sv
package led_status_pkg;
   typedef enum logic [2:0] {
      ATTR_NONE = 3'd0,
      ATTR_CRS  = 3'd1,
      ATTR_COL  = 3'd2,
      ATTR_LINK = 3'd3,
      ATTR_PART = 3'd4,
      ATTR_POL  = 3'd5
   } attr_e;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
   parameter int TICK_DIV = 250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV <= 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = (cnt_q == LAST);

         // R2
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o)
            else $error("tick asserted on consecutive cycles");
      end
   endgenerate
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int HOLD_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ev_i,
   output logic act_o
);
   localparam int CNT_W = $clog2(HOLD_TICKS + 2);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_TICKS + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (ev_i)                    cnt_q <= LOAD;
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign act_o = (cnt_q != '0);

   // R4
   retrig_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i |=> act_o)
      else $error("event not shown on next cycle");

   // R2
   hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_o) |-> ($past(tick_i) && !$past(ev_i)))
      else $error("hold ended without a tick or during an event");
endmodule

// File: rtl/led_attr_decode.sv
module led_attr_decode
   import led_status_pkg::*;
(
   input  logic  sel_crs,
   input  logic  sel_col,
   input  logic  sel_link,
   input  logic  sel_part,
   input  logic  sel_pol,
   output attr_e attr_o
);
   always_comb begin
      if (sel_crs)       attr_o = ATTR_CRS;
      else if (sel_col)  attr_o = ATTR_COL;
      else if (sel_link) attr_o = ATTR_LINK;
      else if (sel_part) attr_o = ATTR_PART;
      else if (sel_pol)  attr_o = ATTR_POL;
      else               attr_o = ATTR_NONE;
   end
endmodule

// File: rtl/led_status_mux.sv
module led_status_mux
   import led_status_pkg::*;
#(
   parameter int LED_W      = 8,
   parameter int EXP_POS    = 6,
   parameter int AUX_POS    = 6,
   parameter int TICK_DIV   = 250000,
   parameter int HOLD_TICKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_crs,
   input  logic             sel_col,
   input  logic             sel_link,
   input  logic             sel_part,
   input  logic             sel_pol,
   input  logic             bank_sel,
   input  logic [LED_W-1:0] crs_i,
   input  logic [LED_W-1:0] col_i,
   input  logic [LED_W-1:0] link_i,
   input  logic [LED_W-1:0] part_i,
   input  logic [LED_W-1:0] pol_i,
   input  logic             exp_crs_i,
   input  logic             exp_col_i,
   input  logic [1:0]       aux_link_i,
   input  logic [1:0]       aux_pol_i,
   output logic [LED_W-1:0] led_o
);
   localparam int AUX_HI = AUX_POS + 1;

   initial begin : param_chk
      assert (LED_W >= 2)        else $error("LED_W must be at least 2");
      assert (EXP_POS < LED_W)   else $error("EXP_POS outside LED bus");
      assert (AUX_HI < LED_W)    else $error("AUX_POS+1 outside LED bus");
      assert (TICK_DIV >= 1)     else $error("TICK_DIV must be positive");
      assert (HOLD_TICKS >= 1)   else $error("HOLD_TICKS must be positive");
   end

   logic             tick;
   logic [LED_W-1:0] crs_held;
   logic [LED_W-1:0] col_held;
   logic             xcrs_held;
   logic             xcol_held;
   attr_e            attr;
   logic [LED_W-1:0] led_d;

   led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   generate
      for (genvar g = 0; g < LED_W; g++) begin : g_port
         led_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_crs (
            .clk(clk), .rst_n(rst_n), .tick_i(tick),
            .ev_i(crs_i[g]), .act_o(crs_held[g])
         );
         led_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_col (
            .clk(clk), .rst_n(rst_n), .tick_i(tick),
            .ev_i(col_i[g]), .act_o(col_held[g])
         );
      end
   endgenerate

   led_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_xcrs (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .ev_i(exp_crs_i), .act_o(xcrs_held)
   );
   led_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_xcol (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .ev_i(exp_col_i), .act_o(xcol_held)
   );

   led_attr_decode u_dec (
      .sel_crs  (sel_crs),
      .sel_col  (sel_col),
      .sel_link (sel_link),
      .sel_part (sel_part),
      .sel_pol  (sel_pol),
      .attr_o   (attr)
   );

   always_comb begin
      led_d = '0;
      case (attr)
         ATTR_CRS: begin
            led_d = crs_held;
            if (bank_sel) led_d[EXP_POS] = xcrs_held;
         end
         ATTR_COL: begin
            led_d = col_held;
            if (bank_sel) led_d[EXP_POS] = xcol_held;
         end
         ATTR_LINK: begin
            led_d = link_i;
            if (bank_sel) led_d[AUX_HI:AUX_POS] = aux_link_i;
         end
         ATTR_PART: begin
            led_d = part_i;
            if (bank_sel) led_d[AUX_HI:AUX_POS] = aux_pol_i;
         end
         ATTR_POL:  led_d = pol_i;
         default:   led_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_o <= '0;
      else        led_o <= led_d;
   end

   // R6
   idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_crs || sel_col || sel_link || sel_part || sel_pol) |=> (led_o == '0))
      else $error("LED lit with no select");

   // R5
   link_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_link && !sel_crs && !sel_col && !bank_sel) |=> (led_o == $past(link_i)))
      else $error("link status not passed through");

   // R9
   aux_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_link && !sel_crs && !sel_col && bank_sel)
         |=> (led_o[AUX_HI:AUX_POS] == $past(aux_link_i)))
      else $error("auxiliary link bits wrong");

   // R11
   pol_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pol && !sel_crs && !sel_col && !sel_link && !sel_part)
         |=> (led_o == $past(pol_i)))
      else $error("polarity display altered");
endmodule

// File: tb/led_status_mux_tb.sv
`timescale 1ns/1ps
module led_status_mux_tb;
   localparam int W   = 8;
   localparam int DIV = 4;
   localparam int HT  = 3;
   localparam int SAFE_ON  = HT * DIV;
   localparam int SURE_OFF = (HT + 2) * DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_crs = 0, s_col = 0, s_link = 0, s_part = 0, s_pol = 0, bank = 0;
   logic [W-1:0] crs = '0, col = '0, lnk = '0, prt = '0, pol = '0;
   logic x_crs = 0, x_col = 0;
   logic [1:0] a_lnk = '0, a_pol = '0;
   logic [W-1:0] led;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   led_status_mux #(
      .LED_W(W), .EXP_POS(6), .AUX_POS(6), .TICK_DIV(DIV), .HOLD_TICKS(HT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .sel_crs(s_crs), .sel_col(s_col), .sel_link(s_link),
      .sel_part(s_part), .sel_pol(s_pol), .bank_sel(bank),
      .crs_i(crs), .col_i(col), .link_i(lnk), .part_i(prt), .pol_i(pol),
      .exp_crs_i(x_crs), .exp_col_i(x_col),
      .aux_link_i(a_lnk), .aux_pol_i(a_pol),
      .led_o(led)
   );

   // {sel crs,col,link,part,pol; bank; link; part; pol; aux_link; aux_pol; expected}
   localparam int NV = 20;
   localparam logic [41:0] VEC [NV] = '{
      {5'b00100, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h5A},
      {5'b00010, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h0F},
      {5'b00001, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hC3},
      {5'b10000, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hA5},
      {5'b01000, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h7C},
      {5'b00000, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h00},
      {5'b10100, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hA5},
      {5'b01011, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h7C},
      {5'b00101, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h5A},
      {5'b00011, 1'b0, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h0F},
      {5'b10000, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hE5},
      {5'b01000, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h3C},
      {5'b00100, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h9A},
      {5'b00010, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hCF},
      {5'b00001, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hC3},
      {5'b00000, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h00},
      {5'b00100, 1'b0, 8'h81, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'h81},
      {5'b00100, 1'b1, 8'h81, 8'h0F, 8'hC3, 2'b01, 2'b11, 8'h41},
      {5'b11111, 1'b1, 8'h5A, 8'h0F, 8'hC3, 2'b10, 2'b11, 8'hE5},
      {5'b00010, 1'b1, 8'h5A, 8'hF0, 8'hC3, 2'b10, 2'b01, 8'h70}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: led=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic string tag_of(input logic [4:0] s, input logic b);
      if ($countones(s) != 1) return "R6";
      if (s[4]) return b ? "R7" : "R2";
      if (s[3]) return b ? "R8" : "R3";
      if (s[2]) return b ? "R9" : "R5";
      if (s[1]) return b ? "R10" : "R5";
      if (s[0]) return "R11";
      return "R6";
   endfunction

   initial begin : watchdog
      #(200000 * 4);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic stayed;
      // R1: reset with selections active
      s_crs = 1; crs = 8'hFF;
      step(3);
      check("R1", led, 8'h00);
      crs = '0;
      rst_n = 1'b1;
      step(1);
      check("R1", led, 8'h00);
      s_crs = 0;

      // table walk, steady stretched inputs
      crs = 8'hA5; col = 8'h7C; x_crs = 1; x_col = 0;
      step(3);
      for (int i = 0; i < NV; i++) begin
         {s_crs, s_col, s_link, s_part, s_pol} = VEC[i][41:37];
         bank  = VEC[i][36];
         lnk   = VEC[i][35:28];
         prt   = VEC[i][27:20];
         pol   = VEC[i][19:12];
         a_lnk = VEC[i][11:10];
         a_pol = VEC[i][9:8];
         step(1);
         check(tag_of(VEC[i][41:37], VEC[i][36]), led, VEC[i][7:0]);
      end

      // clear all holds
      crs = '0; col = '0; x_crs = 0; x_col = 0; bank = 0;
      {s_crs, s_col, s_link, s_part, s_pol} = 5'b10000;
      step(SURE_OFF + 4);
      check("R2", led, 8'h00);

      // R2: one-cycle carrier pulse on port 1
      crs = 8'h02; step(1); crs = '0;
      step(1);
      check("R2", led, 8'h02);
      step(SAFE_ON - 2);
      check("R2", led, 8'h02);
      step(SURE_OFF - SAFE_ON);
      check("R2", led, 8'h00);

      // R3: one-cycle collision pulse on port 4
      {s_crs, s_col} = 2'b01;
      col = 8'h10; step(1); col = '0;
      step(1);
      check("R3", led, 8'h10);
      step(SAFE_ON - 2);
      check("R3", led, 8'h10);
      step(SURE_OFF - SAFE_ON);
      check("R3", led, 8'h00);

      // R4: retrigger right at the end of the guaranteed hold
      {s_crs, s_col} = 2'b10;
      stayed = 1'b1;
      crs = 8'h01; step(1); crs = '0;
      for (int k = 0; k < SAFE_ON; k++) begin
         step(1);
         if (led[0] !== 1'b1) stayed = 1'b0;
      end
      crs = 8'h01; step(1); crs = '0;
      if (led[0] !== 1'b1) stayed = 1'b0;
      for (int k = 0; k < SAFE_ON - 1; k++) begin
         step(1);
         if (led[0] !== 1'b1) stayed = 1'b0;
      end
      check("R4", {7'd0, stayed}, 8'h01);
      step(SURE_OFF - SAFE_ON + 1);
      check("R4", led, 8'h00);

      // R8: expansion collision pulse, bank high
      {s_crs, s_col} = 2'b01; bank = 1;
      x_col = 1; step(1); x_col = 0;
      step(1);
      check("R8", led, 8'h40);
      step(SAFE_ON - 2);
      check("R8", led, 8'h40);
      step(SURE_OFF - SAFE_ON);
      check("R8", led, 8'h00);

      // R12: exactly one edge of latency
      bank = 0;
      {s_crs, s_col, s_link, s_part, s_pol} = 5'b00100;
      lnk = 8'h33; pol = 8'hCC;
      step(2);
      check("R12", led, 8'h33);
      s_link = 0; s_pol = 1;
      #1;
      check("R12", led, 8'h33);
      step(1);
      check("R12", led, 8'hCC);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule